// File: doc/BRIEF.md
# Condition Flag and Branch Decision Unit

This unit keeps the processor's three sign flags (negative, zero, positive) and turns a branch instruction's three-bit condition mask into a single branch-taken bit. Whenever the datapath writes a result into a general register and the decoder raises the flag-load enable, the unit classifies that 16-bit two's complement value and sets exactly one flag, clearing the other two. The decoder raises the flag-load enable only for results that should affect the flags (arithmetic, logic, complement, address-load and memory-load results). Stores and control transfers leave it low, so the flags hold.

During the decode cycle the unit combines the mask with the current flags: the taken bit is the OR of mask bit 2 with the negative flag, mask bit 1 with the zero flag, and mask bit 0 with the positive flag. The result is captured in a register on that cycle. The branch execute step reads it later, and later changes on the mask inputs cannot disturb it.

The flags are held as a three-state machine. The states are `CC_NEG`, `CC_ZERO` and `CC_POS`, and reset enters `CC_ZERO`. On a cycle with the flag-load enable high, the machine moves from any state to the state that matches the sign class of the bus value: `LOAD_NEG` goes to `CC_NEG`, `LOAD_ZERO` goes to `CC_ZERO`, and `LOAD_POS` goes to `CC_POS`. On a cycle with the enable low, the transition `HOLD` keeps the current state.

Top module: `cc_branch_unit`

## Requirements
- R1: After reset, flag_z is 1, flag_n and flag_p are 0, and branch_taken is 0.
- R2: After a clock edge with flag_load high and bit 15 of result_bus set (a negative value), flag_n is 1 and flag_z and flag_p are 0.
- R3: After a clock edge with flag_load high and result_bus equal to 0x0000, flag_z is 1 and flag_n and flag_p are 0.
- R4: After a clock edge with flag_load high and result_bus nonzero with bit 15 clear (for example 0x0001 or 0x7FFF), flag_p is 1 and flag_n and flag_z are 0.
- R5: A clock edge with flag_load low leaves all three flags unchanged, whatever value result_bus carries.
- R6: Exactly one of flag_n, flag_z and flag_p is 1 in every cycle after reset.
- R7: After a clock edge with decode_en high, branch_taken equals (cond_mask[2] & flag_n) | (cond_mask[1] & flag_z) | (cond_mask[0] & flag_p), using the flag and mask values present before that edge.
- R8: A clock edge with decode_en low leaves branch_taken unchanged, whatever the values of cond_mask and the flags.
- R9: When flag_load and decode_en are both high on the same edge, branch_taken uses the flags from before that edge, and the flags take the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| result_bus | input | 16 | Value being written to a general register |
| flag_load | input | 1 | Update the flags from result_bus on this edge |
| decode_en | input | 1 | Decode cycle: capture the branch decision on this edge |
| cond_mask | input | 3 | Branch condition mask, bit 2 = negative, bit 1 = zero, bit 0 = positive |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Positive flag |
| branch_taken | output | 1 | Registered branch-enable bit |

## Verification
The assertions check on every cycle that exactly one flag is set, that the flags hold when no load is requested, that each sign class leads to its flag, and that the branch bit either holds or matches the masked flags from the previous cycle. Some behaviour only the bench's directed scenarios can show. These are the reset values and the boundary values 0x8000, 0xFFFF, 0x0001 and 0x7FFF. They also include all eight mask patterns against each flag state and the same-edge case where a flag load and a decode coincide.

// File: rtl/cc_pkg.sv
package cc_pkg;
    localparam int DATA_W = 16;
    localparam int MASK_W = 3;

    // Index of each flag in the packed {n, z, p} vector
    localparam int IDX_N = 2;
    localparam int IDX_Z = 1;
    localparam int IDX_P = 0;

    typedef enum logic [1:0] {
        CC_NEG  = 2'd0,
        CC_ZERO = 2'd1,
        CC_POS  = 2'd2
    } cc_state_e;
endpackage

// File: rtl/cc_sign_classify.sv
module cc_sign_classify
    import cc_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] value,
    output cc_state_e        sign_class
);
    localparam int MSB = WIDTH - 1;

    logic is_neg;
    logic is_zero;

    assign is_neg  = value[MSB];
    assign is_zero = (value == '0);

    always_comb begin
        if (is_neg)       sign_class = CC_NEG;
        else if (is_zero) sign_class = CC_ZERO;
        else              sign_class = CC_POS;
    end
endmodule

// File: rtl/cc_flag_fsm.sv
module cc_flag_fsm
    import cc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  cc_state_e             sign_class,
    output logic [MASK_W-1:0]     flags
);
    cc_state_e state_q;
    cc_state_e state_d;

    // Next state: LOAD_* moves to the matching class, HOLD keeps the state
    always_comb begin
        state_d = state_q;
        if (load) begin
            unique case (sign_class)
                CC_NEG:  state_d = CC_NEG;
                CC_ZERO: state_d = CC_ZERO;
                CC_POS:  state_d = CC_POS;
                default: state_d = CC_ZERO;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CC_ZERO;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        flags = '0;
        unique case (state_q)
            CC_NEG:  flags[IDX_N] = 1'b1;
            CC_ZERO: flags[IDX_Z] = 1'b1;
            CC_POS:  flags[IDX_P] = 1'b1;
            default: flags[IDX_Z] = 1'b1;
        endcase
    end

    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags) == 1); // R6

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(flags)); // R5
endmodule

// File: rtl/cc_ben_capture.sv
module cc_ben_capture
    import cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [MASK_W-1:0] mask,
    input  logic [MASK_W-1:0] flags,
    output logic              ben
);
    logic [MASK_W-1:0] term;
    logic              ben_d;

    for (genvar i = 0; i < MASK_W; i++) begin : g_term
        assign term[i] = mask[i] & flags[i];
    end

    assign ben_d = |term;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ben <= 1'b0;
        else if (capture) ben <= ben_d;
    end

    AST_BEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(ben)); // R8
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
    import cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] result_bus,
    input  logic              flag_load,
    input  logic              decode_en,
    input  logic [MASK_W-1:0] cond_mask,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_p,
    output logic              branch_taken
);
    cc_state_e         sign_class;
    logic [MASK_W-1:0] flags;

    cc_sign_classify #(.WIDTH(DATA_W)) u_classify (
        .value      (result_bus),
        .sign_class (sign_class)
    );

    cc_flag_fsm u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (flag_load),
        .sign_class (sign_class),
        .flags      (flags)
    );

    cc_ben_capture u_ben (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (decode_en),
        .mask    (cond_mask),
        .flags   (flags),
        .ben     (branch_taken)
    );

    assign flag_n = flags[IDX_N];
    assign flag_z = flags[IDX_Z];
    assign flag_p = flags[IDX_P];

    AST_NEG_SETS_N: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_load && result_bus[DATA_W-1]) |=> (flag_n && !flag_z && !flag_p)); // R2

    AST_ZERO_SETS_Z: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_load && result_bus == '0) |=> (flag_z && !flag_n && !flag_p)); // R3

    AST_POS_SETS_P: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_load && !result_bus[DATA_W-1] && result_bus != '0)
            |=> (flag_p && !flag_n && !flag_z)); // R4

    AST_BEN_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        decode_en |=> branch_taken == (($past(cond_mask[2]) && $past(flag_n)) ||
                                       ($past(cond_mask[1]) && $past(flag_z)) ||
                                       ($past(cond_mask[0]) && $past(flag_p)))); // R7 R9
endmodule

// File: tb/cc_branch_unit_tb.sv
module cc_branch_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] result_bus = '0;
    logic        flag_load = 1'b0;
    logic        decode_en = 1'b0;
    logic [2:0]  cond_mask = '0;
    logic        flag_n, flag_z, flag_p, branch_taken;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cc_branch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .result_bus(result_bus),
        .flag_load(flag_load), .decode_en(decode_en), .cond_mask(cond_mask),
        .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p),
        .branch_taken(branch_taken)
    );

    // Bench model of the flags, {n,z,p}
    logic [2:0] exp_flags = 3'b010;

    function automatic logic [2:0] classify(input logic [15:0] v);
        if (v[15])          return 3'b100;
        else if (v == 16'h0) return 3'b010;
        else                return 3'b001;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_flags(input string req);
        check(req, {1'b0, flag_n, flag_z, flag_p}, {1'b0, exp_flags});
    endtask

    // Drive one flag load, then sample at the next falling edge
    task automatic do_load(input logic [15:0] v);
        @(negedge clk);
        result_bus = v;
        flag_load  = 1'b1;
        @(negedge clk);
        flag_load  = 1'b0;
        exp_flags  = classify(v);
    endtask

    task automatic do_decode(input logic [2:0] m, output logic exp_ben);
        exp_ben = |(m & exp_flags);
        @(negedge clk);
        cond_mask = m;
        decode_en = 1'b1;
        @(negedge clk);
        decode_en = 1'b0;
    endtask

    task automatic test_reset();
        check("R1 flags", {1'b0, flag_n, flag_z, flag_p}, 4'b0010);
        check("R1 ben", {3'b0, branch_taken}, 4'b0000);
    endtask

    task automatic test_classes();
        do_load(16'h8000); check_flags("R2 0x8000");
        do_load(16'h0001); check_flags("R4 0x0001");
        do_load(16'hFFFF); check_flags("R2 0xFFFF");
        do_load(16'h0000); check_flags("R3 zero");
        do_load(16'h7FFF); check_flags("R4 0x7FFF");
        do_load(16'h0000); check_flags("R3 zero after pos");
    endtask

    task automatic test_hold();
        do_load(16'h1234);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            result_bus = (i == 0) ? 16'h0000 : (i == 1) ? 16'h8001 : 16'h5555;
            @(negedge clk);
            check_flags("R5 hold");
            check(
                "R6 one flag", {1'b0, 3'(($countones({flag_n, flag_z, flag_p}) == 1))},
                4'b0001);
        end
    endtask

    task automatic test_ben_masks();
        logic eb;
        logic [15:0] vals [3] = '{16'hF000, 16'h0000, 16'h0042};
        for (int s = 0; s < 3; s++) begin
            do_load(vals[s]);
            for (int m = 0; m < 8; m++) begin
                do_decode(3'(m), eb);
                check("R7 ben", {3'b0, branch_taken}, {3'b0, eb});
            end
        end
    endtask

    task automatic test_ben_hold();
        logic eb;
        do_load(16'h0000);
        do_decode(3'b010, eb);
        check("R8 setup", {3'b0, branch_taken}, 4'b0001);
        @(negedge clk);
        cond_mask = 3'b000;
        do_load(16'h9000);
        @(negedge clk);
        check("R8 hold", {3'b0, branch_taken}, 4'b0001);
    endtask

    task automatic test_same_edge();
        // flags currently N; decode with mask N while loading zero
        @(negedge clk);
        cond_mask  = 3'b100;
        decode_en  = 1'b1;
        result_bus = 16'h0000;
        flag_load  = 1'b1;
        @(negedge clk);
        decode_en = 1'b0;
        flag_load = 1'b0;
        exp_flags = 3'b010;
        check("R9 ben old flags", {3'b0, branch_taken}, 4'b0001);
        check_flags("R9 new flags");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                test_reset();
                rst_n = 1'b1;
                test_reset();
                test_classes();
                test_hold();
                test_ben_masks();
                test_ben_hold();
                test_same_edge();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule